// File: doc/BRIEF.md
# UART Interrupt Identification and FIFO Control

This block ranks the interrupt sources of a 16550-style UART and decodes the FIFO control register. The receive FIFO, the transmit FIFO, the line-error logic and the modem-change logic report to it through flags, event pulses and occupancy counts. The block returns the identification byte that the host reads at offset 2, and it drives one interrupt line. Host writes to offset 2 go to the write-only FIFO control register. That register sets the FIFO enable and the receive trigger level, and it fires one-cycle reset pulses at the FIFOs.

Line-status and modem-status events are latched inside the block until the host reads the matching status register. The transmit request is raised when the transmitter enters its request condition. It is removed by a transmit write, or by an identification read that reports it. The block measures the receive character timeout itself, using baud ticks supplied from outside. The FIFO storage, the shifters and the baud generator are outside this block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, `iir_rdata` reads 8'h01, `irq` is low, `fifo_en` is low, `rx_trig8` is low and both FIFO reset pulses are low.
- R2: A write with `fcr_wr` high loads `fifo_en` from `wdata[0]`. `iir_rdata[7:6]` reads 2'b11 while `fifo_en` is high and 2'b00 otherwise. `iir_rdata[5:4]` always reads zero.
- R3: When `wdata[1]` is set in a control write, `rx_fifo_rst` is high for exactly the one cycle after that write. `wdata[2]` drives `tx_fifo_rst` in the same way. Neither bit is stored.
- R4: A control write with `wdata[7:6]` = 2'b10 selects a receive trigger of 8 bytes and sets `rx_trig8`. Codes 00, 01 and 11 select a trigger of 1 byte. `rx_dma_req` is high exactly when `fifo_en` is high and the receive count is at or above the trigger.
- R5: `iir_rdata[3:0]` reports the highest-priority enabled source, using these codes: line status 4'b0110, which wins over everything; received data 4'b0100, then timeout 4'b1100; transmit request 4'b0010; modem status 4'b0000, which ranks lowest. With no source pending it reads 4'b0001.
- R6: A `line_evt` pulse latches a pending line-status source. A `lsr_rd` pulse clears it.
- R7: In FIFO mode, received data is pending while `rx_count` is at or above the trigger. In non-FIFO mode, it is pending while `rx_count` is non-zero.
- R8: In FIFO mode with `rx_count` non-zero, the timeout becomes pending after 4 × TICKS_PER_CHAR `baud_tick` cycles pass with no `rx_push` and no `rbr_rd`. Either of those pulses restarts the count. The timeout clears on `rbr_rd` or on a receive FIFO reset pulse.
- R9: The transmit request condition is `tx_count` ≤ FIFO_DEPTH/2 in FIFO mode, or `tx_count` = 0 in non-FIFO mode. The request becomes pending on the cycle after the condition turns true. It clears on `thr_wr`, or on `iir_rd` while 4'b0010 is the reported code.
- R10: A `modem_evt` pulse latches a pending modem-status source. A `msr_rd` pulse clears it.
- R11: The `ier_mask` bits gate the sources: bit 0 gates received data and timeout, bit 1 the transmit request, bit 2 line status and bit 3 modem status. A masked source never appears in the code. `irq` is high exactly when the code is not 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fcr_wr | input | 1 | Write strobe for the FIFO control register at offset 2 |
| wdata | input | 8 | Host write data |
| iir_rd | input | 1 | Read strobe for the identification register at offset 2 |
| iir_rdata | output | 8 | Identification byte |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| rbr_rd | input | 1 | Receive data read strobe |
| thr_wr | input | 1 | Transmit data write strobe |
| ier_mask | input | 4 | Interrupt enable bits |
| line_evt | input | 1 | Pulse on overrun, parity, framing or break |
| modem_evt | input | 1 | Pulse on a CTS, DSR, RI or DCD change |
| rx_push | input | 1 | Pulse when a byte enters the receive FIFO |
| rx_count | input | 5 | Receive FIFO occupancy |
| tx_count | input | 5 | Transmit FIFO occupancy |
| baud_tick | input | 1 | Timing tick for the character timeout |
| irq | output | 1 | Interrupt request |
| fifo_en | output | 1 | FIFO mode enable |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO reset |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO reset |
| rx_trig8 | output | 1 | Receive trigger is 8 bytes |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that the count inputs stay within 0 to FIFO_DEPTH, and that the strobes are single-cycle pulses from one host access at a time. The bench holds `rx_count` at zero across every control write of the trigger sweep, so that no timeout builds up from one sweep point to the next. It drives each event and each status read as a one-cycle pulse. The transmit count is parked at FIFO_DEPTH whenever the transmit request is not under test, so no transmit request can become pending and mask the other sources.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_LINE = 4'b0110;
  localparam logic [3:0] ID_RXD  = 4'b0100;
  localparam logic [3:0] ID_TMO  = 4'b1100;
  localparam logic [3:0] ID_TX   = 4'b0010;
  localparam logic [3:0] ID_MDM  = 4'b0000;

  localparam int EN_RX  = 0;
  localparam int EN_TX  = 1;
  localparam int EN_LS  = 2;
  localparam int EN_MDM = 3;
endpackage

// File: rtl/uart_fcr_regs.sv
module uart_fcr_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       fen,
  output logic       trig8,
  output logic       rxr,
  output logic       txr
);
  logic fen_d, trig8_d, rxr_d, txr_d;
  logic fen_q, trig8_q, rxr_q, txr_q;

  always_comb begin
    fen_d   = fen_q;
    trig8_d = trig8_q;
    rxr_d   = 1'b0;
    txr_d   = 1'b0;
    if (wr) begin
      fen_d   = wdata[0];
      trig8_d = (wdata[7:6] == 2'b10);
      rxr_d   = wdata[1];
      txr_d   = wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q   <= 1'b0;
      trig8_q <= 1'b0;
      rxr_q   <= 1'b0;
      txr_q   <= 1'b0;
    end else begin
      fen_q   <= fen_d;
      trig8_q <= trig8_d;
      rxr_q   <= rxr_d;
      txr_q   <= txr_d;
    end
  end

  assign fen   = fen_q;
  assign trig8 = trig8_q;
  assign rxr   = rxr_q;
  assign txr   = txr_q;

  assert_rx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rxr_q |=> !rxr_q || $past(wr && wdata[1]));
  assert_tx_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txr_q) |-> $past(wr && wdata[2]));
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int FIFO_DEPTH     = 16,
  parameter int TICKS_PER_CHAR = 16,
  parameter int CHAR_TIMES     = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int LIMIT = TICKS_PER_CHAR * CHAR_TIMES,
  localparam int TMR_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fen,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rbr_rd,
  input  logic             rx_rst,
  input  logic             tick,
  output logic             tmo
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             empty, restart, drop;

  assign empty   = (rx_count == '0);
  assign drop    = rbr_rd | rx_rst | ~fen | empty;
  assign restart = drop | rx_push;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (drop) flag_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (tick && !flag_q) begin
      if (cnt_q == TMR_W'(LIMIT - 1)) begin
        flag_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign tmo = flag_q;

  assert_tmo_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(fen) && ($past(rx_count) != '0) && !$past(rx_push) && !$past(rbr_rd));
  assert_tmo_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd || rx_rst) |=> !flag_q);
endmodule

// File: rtl/uart_int_prio.sv
module uart_int_prio
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ier,
  input  logic       line_evt,
  input  logic       modem_evt,
  input  logic       lsr_rd,
  input  logic       msr_rd,
  input  logic       thr_wr,
  input  logic       iir_rd,
  input  logic       rda,
  input  logic       tmo,
  input  logic       tx_cond,
  output logic [3:0] id,
  output logic       irq
);
  logic ls_q, ls_d, ms_q, ms_d, txp_q, txp_d, txc_q;

  always_comb begin
    if (ier[EN_LS] && ls_q)          id = ID_LINE;
    else if (ier[EN_RX] && rda)      id = ID_RXD;
    else if (ier[EN_RX] && tmo)      id = ID_TMO;
    else if (ier[EN_TX] && txp_q)    id = ID_TX;
    else if (ier[EN_MDM] && ms_q)    id = ID_MDM;
    else                             id = ID_NONE;
  end

  always_comb begin
    ls_d  = line_evt | (ls_q & ~lsr_rd);
    ms_d  = modem_evt | (ms_q & ~msr_rd);
    txp_d = txp_q;
    if (thr_wr || (iir_rd && id == ID_TX)) txp_d = 1'b0;
    if (tx_cond && !txc_q) txp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q  <= 1'b0;
      ms_q  <= 1'b0;
      txp_q <= 1'b0;
      txc_q <= 1'b0;
    end else begin
      ls_q  <= ls_d;
      ms_q  <= ms_d;
      txp_q <= txp_d;
      txc_q <= tx_cond;
    end
  end

  assign irq = (id != ID_NONE);

  assert_line_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ier[EN_LS] && ls_q) |-> id == ID_LINE);
  assert_line_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !line_evt) |=> !ls_q);
  assert_mdm_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !modem_evt) |=> !ms_q);
  assert_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'b0000) |-> !irq);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH     = 16,
  parameter int TICKS_PER_CHAR = 16,
  parameter int CHAR_TIMES     = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int HALF  = FIFO_DEPTH / 2,
  localparam int TRIG_HI = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fcr_wr,
  input  logic [7:0]       wdata,
  input  logic             iir_rd,
  output logic [7:0]       iir_rdata,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             rbr_rd,
  input  logic             thr_wr,
  input  logic [3:0]       ier_mask,
  input  logic             line_evt,
  input  logic             modem_evt,
  input  logic             rx_push,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             baud_tick,
  output logic             irq,
  output logic             fifo_en,
  output logic             rx_fifo_rst,
  output logic             tx_fifo_rst,
  output logic             rx_trig8,
  output logic             rx_dma_req
);
  logic [3:0]       id;
  logic             rda, tmo, tx_cond;
  logic [CNT_W-1:0] thresh;

  uart_fcr_regs u_fcr (
    .clk(clk), .rst_n(rst_n), .wr(fcr_wr), .wdata(wdata),
    .fen(fifo_en), .trig8(rx_trig8), .rxr(rx_fifo_rst), .txr(tx_fifo_rst)
  );

  assign thresh  = rx_trig8 ? CNT_W'(TRIG_HI) : CNT_W'(1);
  assign rda     = fifo_en ? (rx_count >= thresh) : (rx_count != '0);
  assign tx_cond = fifo_en ? (tx_count <= CNT_W'(HALF)) : (tx_count == '0);
  assign rx_dma_req = fifo_en & rda;

  uart_rx_timeout #(
    .FIFO_DEPTH(FIFO_DEPTH), .TICKS_PER_CHAR(TICKS_PER_CHAR), .CHAR_TIMES(CHAR_TIMES)
  ) u_tmo (
    .clk(clk), .rst_n(rst_n), .fen(fifo_en), .rx_count(rx_count),
    .rx_push(rx_push), .rbr_rd(rbr_rd), .rx_rst(rx_fifo_rst),
    .tick(baud_tick), .tmo(tmo)
  );

  uart_int_prio u_prio (
    .clk(clk), .rst_n(rst_n), .ier(ier_mask), .line_evt(line_evt),
    .modem_evt(modem_evt), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr),
    .iir_rd(iir_rd), .rda(rda), .tmo(tmo), .tx_cond(tx_cond), .id(id), .irq(irq)
  );

  assign iir_rdata = {fifo_en, fifo_en, 2'b00, id};

  assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    id == ID_NONE || id == ID_LINE || id == ID_RXD || id == ID_TMO || id == ID_TX || id == ID_MDM);
  assert_tx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && $stable(tx_count) && $stable(fifo_en)) |=> (id != ID_TX));
  assert_dma_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> fifo_en && rx_count != '0);
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module uart_irq_ctrl_tb_top;
  localparam int LIMIT = 16 * 4;

  logic clk = 1'b0;
  logic rst_n;
  logic fcr_wr, iir_rd, lsr_rd, msr_rd, rbr_rd, thr_wr;
  logic line_evt, modem_evt, rx_push, baud_tick;
  logic [7:0] wdata, iir_rdata;
  logic [3:0] ier_mask;
  logic [4:0] rx_count, tx_count;
  logic irq, fifo_en, rx_fifo_rst, tx_fifo_rst, rx_trig8, rx_dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .wdata(wdata), .iir_rd(iir_rd),
    .iir_rdata(iir_rdata), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .rbr_rd(rbr_rd),
    .thr_wr(thr_wr), .ier_mask(ier_mask), .line_evt(line_evt), .modem_evt(modem_evt),
    .rx_push(rx_push), .rx_count(rx_count), .tx_count(tx_count), .baud_tick(baud_tick),
    .irq(irq), .fifo_en(fifo_en), .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst),
    .rx_trig8(rx_trig8), .rx_dma_req(rx_dma_req)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fcr(input logic [7:0] v);
    fcr_wr = 1'b1; wdata = v;
    tick();
    fcr_wr = 1'b0; wdata = 8'h00;
  endtask

  function automatic logic [3:0] prio(input logic [3:0] en, input bit ls, input bit rd, input bit ms);
    if (en[2] && ls) return 4'b0110;
    if (en[0] && rd) return 4'b0100;
    if (en[3] && ms) return 4'b0000;
    return 4'b0001;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {fcr_wr, iir_rd, lsr_rd, msr_rd, rbr_rd, thr_wr} = '0;
    {line_evt, modem_evt, rx_push} = '0;
    baud_tick = 1'b1; wdata = 8'h00; ier_mask = 4'h0;
    rx_count = 5'd0; tx_count = 5'd16;
    repeat (3) tick();
    // R1 reset state
    chk("R1 iir", iir_rdata, 8'h01);
    chk("R1 irq", irq, 0);
    chk("R1 fen/trig/rst", {fifo_en, rx_trig8, rx_fifo_rst, tx_fifo_rst}, 4'b0000);
    rst_n = 1'b1;
    tick();
    chk("R1 iir after release", iir_rdata, 8'h01);

    // R3 reset pulses, not stored
    fcr(8'h07);
    chk("R3 rx pulse", rx_fifo_rst, 1);
    chk("R3 tx pulse", tx_fifo_rst, 1);
    chk("R2 fifo_en", fifo_en, 1);
    tick();
    chk("R3 pulses end", {rx_fifo_rst, tx_fifo_rst}, 2'b00);
    fcr(8'h00);
    chk("R2 fifo off", fifo_en, 0);
    chk("R2 iir top bits off", iir_rdata[7:4], 4'h0);

    // R4 R7 R2 sweep trigger code x mode x count
    ier_mask = 4'b0001;
    for (int fe = 0; fe < 2; fe++) begin
      for (int code = 0; code < 4; code++) begin
        for (int c = 0; c <= 16; c++) begin
          int thr;
          bit rd;
          rx_count = 5'd0;
          fcr({code[1:0], 5'b00000, fe[0]});
          rx_count = c[4:0];
          #1;
          thr = (fe == 1 && code == 2) ? 8 : 1;
          rd  = (fe == 1) ? (c >= thr) : (c != 0);
          chk("R7 rx data code", iir_rdata, {fe[0], fe[0], 2'b00, rd ? 4'b0100 : 4'b0001});
          chk("R4 dma", rx_dma_req, (fe == 1) && rd);
          chk("R4 trig8", rx_trig8, (code == 2));
          chk("R11 irq", irq, rd);
        end
      end
    end
    rx_count = 5'd0;

    // R5 R6 R10 R11 priority sweep
    fcr(8'h01);
    for (int en = 0; en < 16; en++) begin
      for (int m = 0; m < 8; m++) begin
        logic [3:0] e;
        ier_mask = en[3:0];
        rx_count = m[1] ? 5'd8 : 5'd0;
        line_evt = m[0];
        modem_evt = m[2];
        tick();
        line_evt = 1'b0; modem_evt = 1'b0;
        e = prio(en[3:0], m[0], m[1], m[2]);
        chk("R5 priority code", iir_rdata[3:0], e);
        chk("R11 irq gating", irq, e != 4'b0001);
        lsr_rd = 1'b1; msr_rd = 1'b1; rx_count = 5'd0;
        tick();
        lsr_rd = 1'b0; msr_rd = 1'b0;
        chk("R6 R10 cleared", iir_rdata[3:0], 4'b0001);
      end
    end

    // R6 line status held until lsr read
    ier_mask = 4'b1111;
    line_evt = 1'b1; tick(); line_evt = 1'b0;
    repeat (3) tick();
    chk("R6 held", iir_rdata[3:0], 4'b0110);
    lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
    chk("R6 cleared", iir_rdata[3:0], 4'b0001);
    modem_evt = 1'b1; tick(); modem_evt = 1'b0;
    repeat (2) tick();
    chk("R10 held", iir_rdata[3:0], 4'b0000);
    msr_rd = 1'b1; tick(); msr_rd = 1'b0;
    chk("R10 cleared", irq, 0);

    // R8 timeout: trigger 8, three bytes
    ier_mask = 4'b0001;
    fcr(8'h81);
    rx_count = 5'd3; rx_push = 1'b1; tick(); rx_push = 1'b0;
    repeat (LIMIT - 1) tick();
    chk("R8 not yet", iir_rdata[3:0], 4'b0001);
    tick();
    chk("R8 timeout", iir_rdata[3:0], 4'b1100);
    rbr_rd = 1'b1; rx_count = 5'd2; tick(); rbr_rd = 1'b0;
    chk("R8 cleared by read", iir_rdata[3:0], 4'b0001);
    repeat (LIMIT / 2) tick();
    rx_push = 1'b1; rx_count = 5'd3; tick(); rx_push = 1'b0;
    repeat (LIMIT - 1) tick();
    chk("R8 restart by push", iir_rdata[3:0], 4'b0001);
    tick();
    chk("R8 timeout again", iir_rdata[3:0], 4'b1100);
    fcr(8'h83);
    tick();
    chk("R8 cleared by rx reset", iir_rdata[3:0], 4'b0001);
    rx_count = 5'd0;
    fcr(8'h00);
    tick();
    chk("R8 non-fifo none", iir_rdata[3:0], 4'b0001);

    // R9 transmit request
    ier_mask = 4'b0010;
    fcr(8'h01);
    tx_count = 5'd9; tick(); tick();
    chk("R9 above half", irq, 0);
    tx_count = 5'd8; tick(); tick();
    chk("R9 at half", iir_rdata[3:0], 4'b0010);
    iir_rd = 1'b1; tick(); iir_rd = 1'b0;
    chk("R9 cleared by iir read", irq, 0);
    tx_count = 5'd12; tick();
    tx_count = 5'd4; tick(); tick();
    chk("R9 re-enter", iir_rdata[3:0], 4'b0010);
    thr_wr = 1'b1; tick(); thr_wr = 1'b0;
    chk("R9 cleared by write", irq, 0);
    tx_count = 5'd16;
    fcr(8'h00);
    tx_count = 5'd1; tick(); tick();
    chk("R9 non-fifo one byte", irq, 0);
    tx_count = 5'd0; tick(); tick();
    chk("R9 non-fifo empty", iir_rdata, 8'h02);
    ier_mask = 4'b0000; #1;
    chk("R11 masked tx", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule